// File: doc/BRIEF.md
# Status Byte Service Request Logic

This block holds an 8-bit status byte whose bits are summaries already produced by event sources elsewhere in the design, together with an 8-bit enable mask that chooses which of those summaries may call for attention. From the enabled summaries it forms two flags that share bit position 6. The first is a level-sensitive master summary, which stays high while any enabled summary is high. The second is an edge-triggered request flag, which is set when an enabled summary goes from 0 to 1. The request flag drives the service request output.

The status byte captures the summary inputs on every clock. Only positions 0, 2, 3, 4, 5 and 7 carry summaries. A host reads the status byte through a serial poll strobe. The byte it gets has the request flag in bit 6, taken before the poll clears it. Once a poll has cleared the request flag, a later rising edge raises it again, even if the summary that caused the earlier request is still high. A clear-status strobe empties the byte and drops the request flag. A synchronous reset takes the place of a power cycle.

Top module: `status_service_req`

## Requirements
- R1: Status bits 0, 2, 3, 4, 5 and 7 follow `summ_in` one clock later. Bits 1 and 6 of `summ_in` are ignored, and bit 1 of `stb_byte` always reads 0.
- R2: `mss` is high exactly when the registered status byte ANDed with the mask is nonzero. It tracks the registers with no further delay.
- R3: A summary bit whose mask bit is 0 never sets `srq` and never raises `mss`, however it toggles.
- R4: When a bit of (status AND mask) is 1 and was 0 on the previous clock, the request flag is set on the next clock. `srq` then rises and bit 6 of `stb_byte` reads 1.
- R5: A `poll` pulse with no rising edge in the same cycle clears the request flag at that clock edge. During the pulse, `stb_byte` shows the flag still set. `mss` is not changed by the poll.
- R6: When a rising edge and a `poll` fall in the same cycle, the request flag stays set.
- R7: After a poll, a new rising edge on an enabled bit sets the request flag again, even while another enabled summary has stayed high the whole time.
- R8: A `mask_we` pulse loads `mask_wdata` into the mask with bit 6 forced to 0, and writing 0 clears the mask. `mask_rd` returns the mask. Without `mask_we` the mask holds its value.
- R9: A `clr_stat` pulse clears the status byte and the request flag on the next clock, and leaves the mask as it was. It also clears the edge history, so a summary that is still high is captured again on the clock after that, and it raises a new request one clock later still.
- R10: While `rst` is high at a clock edge, the status byte, mask, edge history and request flag all go to 0.
- R11: Setting a mask bit while its status bit is already 1 counts as a rising edge and raises a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-cycle stand-in) |
| summ_in | input | 8 | Summary bits from the event sources |
| mask_we | input | 1 | Enable mask write strobe |
| mask_wdata | input | 8 | Enable mask write data |
| mask_rd | output | 8 | Enable mask readback (bit 6 always 0) |
| clr_stat | input | 1 | Clear-status strobe |
| poll | input | 1 | Serial poll strobe; acknowledges the request |
| stb_byte | output | 8 | Status byte with the request flag in bit 6 |
| mss | output | 1 | Master summary (level) |
| srq | output | 1 | Service request output |

## Verification
The bench builds the block with its default parameters: an 8-bit byte, the request flag at position 6, and the summary map 0xBD. With these values both unused positions are in play. Bit 1 can be written into the mask but never matches a status bit, and bit 6 is dropped from both inputs. Random summary, mask, poll and clear traffic makes edges coincide with polls and clears and makes masks change under summaries that are already high. Directed sequences pin down re-arming after a poll while another summary stays high, and re-reporting after a clear.

// File: rtl/stb_pkg.sv
package stb_pkg;

    localparam int STB_W = 8;
    localparam int RQ_POS = 6;
    localparam logic [STB_W-1:0] SUM_MAP = 8'hBD;

    typedef logic [STB_W-1:0] stb_vec_t;

    typedef struct packed {
        logic pend;
        logic level;
    } req_flags_t;

    function automatic stb_vec_t place_flag(stb_vec_t stat, logic flag);
        stb_vec_t v;
        v = stat;
        v[RQ_POS] = flag;
        return v;
    endfunction

endpackage

// File: rtl/sr_status_reg.sv
module sr_status_reg #(
    parameter int W = stb_pkg::STB_W,
    parameter logic [W-1:0] MAP = stb_pkg::SUM_MAP
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [W-1:0] summ_in,
    output logic [W-1:0] stat_q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (MAP[i]) begin : g_used
            logic q;
            always_ff @(posedge clk) begin
                if (rst || clr) q <= 1'b0;
                else            q <= summ_in[i];
            end
            assign stat_q[i] = q;
        end else begin : g_unused
            assign stat_q[i] = 1'b0;
        end
    end

    // R9
    stat_clr_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (stat_q == '0));

endmodule

// File: rtl/sr_enable_mask.sv
module sr_enable_mask #(
    parameter int W = stb_pkg::STB_W,
    parameter int RQ_POS = stb_pkg::RQ_POS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask_q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i != RQ_POS) begin : g_store
            logic q;
            always_ff @(posedge clk) begin
                if (rst)     q <= 1'b0;
                else if (we) q <= wdata[i];
            end
            assign mask_q[i] = q;
        end else begin : g_fixed
            assign mask_q[i] = 1'b0;
        end
    end

    // R8
    mask_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (we && wdata == '0) |=> (mask_q == '0));

    // R8
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(mask_q));

endmodule

// File: rtl/sr_request_gen.sv
module sr_request_gen #(
    parameter int W = stb_pkg::STB_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         poll,
    input  logic [W-1:0] stat,
    input  logic [W-1:0] mask,
    output stb_pkg::req_flags_t flags
);

    logic [W-1:0] gated;
    logic [W-1:0] rise;
    logic         pend_q;

    for (genvar i = 0; i < W; i++) begin : g_edge
        logic prev;
        assign gated[i] = stat[i] & mask[i];
        always_ff @(posedge clk) begin
            if (rst || clr) prev <= 1'b0;
            else            prev <= gated[i];
        end
        assign rise[i] = gated[i] & ~prev;
    end

    always_ff @(posedge clk) begin
        if (rst || clr)  pend_q <= 1'b0;
        else if (|rise)  pend_q <= 1'b1;
        else if (poll)   pend_q <= 1'b0;
    end

    always_comb begin
        flags.level = |gated;
        flags.pend  = pend_q;
    end

    // R4
    rise_sets_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(flags.level) && !clr) |=> flags.pend);

    // R5
    poll_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (poll && !clr && $stable(stat) && $stable(mask)) |=> !flags.pend);

    // R9
    clr_drops_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> !flags.pend);

endmodule

// File: rtl/status_service_req.sv
module status_service_req (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] summ_in,
    input  logic       mask_we,
    input  logic [7:0] mask_wdata,
    output logic [7:0] mask_rd,
    input  logic       clr_stat,
    input  logic       poll,
    output logic [7:0] stb_byte,
    output logic       mss,
    output logic       srq
);
    import stb_pkg::*;

    stb_vec_t   stat;
    stb_vec_t   mask;
    req_flags_t flags;

    sr_status_reg #(.W(STB_W), .MAP(SUM_MAP)) u_stat (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr_stat),
        .summ_in (summ_in),
        .stat_q  (stat)
    );

    sr_enable_mask #(.W(STB_W), .RQ_POS(RQ_POS)) u_mask (
        .clk    (clk),
        .rst    (rst),
        .we     (mask_we),
        .wdata  (mask_wdata),
        .mask_q (mask)
    );

    sr_request_gen #(.W(STB_W)) u_req (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr_stat),
        .poll  (poll),
        .stat  (stat),
        .mask  (mask),
        .flags (flags)
    );

    assign mask_rd  = mask;
    assign stb_byte = place_flag(stat, flags.pend);
    assign mss      = flags.level;
    assign srq      = flags.pend;

    // R3
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mask == '0 && !srq) |=> !srq);

endmodule

// File: tb/test_status_service_req.sv
module test_status_service_req;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] VALID = 8'hBD;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] summ_in;
    logic       mask_we;
    logic [7:0] mask_wdata;
    logic [7:0] mask_rd;
    logic       clr_stat;
    logic       poll;
    logic [7:0] stb_byte;
    logic       mss;
    logic       srq;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_stat, m_mask, m_prev;
    logic       m_rqs;

    status_service_req i_status_service_req (
        .clk(clk), .rst(rst), .summ_in(summ_in), .mask_we(mask_we),
        .mask_wdata(mask_wdata), .mask_rd(mask_rd), .clr_stat(clr_stat),
        .poll(poll), .stb_byte(stb_byte), .mss(mss), .srq(srq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] exp_byte(logic [7:0] st, logic r);
        return (st & VALID & 8'hBF) | {1'b0, r, 6'b0};
    endfunction

    function automatic logic exp_mss(logic [7:0] st, logic [7:0] mk);
        return |(st & mk);
    endfunction

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cmp_model(string tag);
        chk({tag, " byte"}, stb_byte, exp_byte(m_stat, m_rqs));
        chk({tag, " mss"},  {7'b0, mss}, {7'b0, exp_mss(m_stat, m_mask)});
        chk({tag, " srq"},  {7'b0, srq}, {7'b0, m_rqs});
        chk({tag, " mask"}, mask_rd, m_mask);
    endtask

    // one clock: inputs already driven at a negedge
    task automatic step(string tag);
        logic [7:0] gated, rise, n_stat, n_mask, n_prev;
        logic n_rqs;
        gated = m_stat & m_mask;
        rise  = gated & ~m_prev;
        if (rst) begin
            n_stat = '0; n_mask = '0; n_prev = '0; n_rqs = 1'b0;
        end else begin
            n_stat = clr_stat ? 8'h00 : (summ_in & VALID);
            n_mask = mask_we ? (mask_wdata & 8'hBF) : m_mask;
            n_prev = clr_stat ? 8'h00 : gated;
            if (clr_stat)   n_rqs = 1'b0;
            else if (|rise) n_rqs = 1'b1;
            else if (poll)  n_rqs = 1'b0;
            else            n_rqs = m_rqs;
        end
        @(negedge clk);
        m_stat = n_stat; m_mask = n_mask; m_prev = n_prev; m_rqs = n_rqs;
        cmp_model(tag);
    endtask

    task automatic idle();
        mask_we = 0; clr_stat = 0; poll = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0017));
        rst = 1; summ_in = 0; mask_wdata = 0; idle();
        m_stat = 0; m_mask = 0; m_prev = 0; m_rqs = 0;
        @(negedge clk);
        summ_in = 8'hFF; mask_we = 1; mask_wdata = 8'hFF;
        step("R10 reset");
        chk("R10 srq", {7'b0, srq}, 8'h00);
        rst = 0; idle(); summ_in = 0;
        step("R10 idle");

        // R8 mask write, bit 6 dropped, zero clears
        mask_we = 1; mask_wdata = 8'hFF; step("R8 write");
        chk("R8 readback", mask_rd, 8'hBF);
        mask_wdata = 8'h00; step("R8 zero");
        chk("R8 cleared", mask_rd, 8'h00);
        idle();

        // R1 / R3 with mask zero
        summ_in = 8'hFF; step("R1 capture");
        chk("R1 byte", stb_byte, 8'hBD);
        summ_in = 8'h00; step("R3 low");
        summ_in = 8'hFF; step("R3 high");
        step("R3 settle");
        chk("R3 srq", {7'b0, srq}, 8'h00);
        chk("R3 mss", {7'b0, mss}, 8'h00);

        // R11 enabling mask on a set bit
        summ_in = 8'h01; step("R11 src");
        mask_we = 1; mask_wdata = 8'h01; step("R11 enable");
        idle(); step("R11 edge");
        chk("R11 srq", {7'b0, srq}, 8'h01);

        // R5 poll clears, reads pre-clear value, mss stays
        poll = 1;
        chk("R5 poll byte", stb_byte, 8'h41);
        step("R5 poll");
        idle();
        chk("R5 srq", {7'b0, srq}, 8'h00);
        chk("R5 mss", {7'b0, mss}, 8'h01);

        // R7 re-arm while another enabled bit stays high
        mask_we = 1; mask_wdata = 8'h05; summ_in = 8'h05; step("R7 mask");
        idle(); step("R7 edge");
        chk("R7 first", {7'b0, srq}, 8'h01);
        poll = 1; step("R7 poll"); idle();
        summ_in = 8'h04; step("R7 drop");
        summ_in = 8'h05; step("R7 back");
        step("R7 edge2");
        chk("R7 rearm", {7'b0, srq}, 8'h01);

        // R6 edge and poll same cycle
        poll = 1; step("R6 clear"); idle();
        summ_in = 8'h04; step("R6 drop");
        summ_in = 8'h05; step("R6 cap");
        poll = 1; step("R6 both"); idle();
        chk("R6 srq", {7'b0, srq}, 8'h01);

        // R9 clear-status
        clr_stat = 1; step("R9 clr"); idle();
        chk("R9 byte", stb_byte, 8'h00);
        chk("R9 mask", mask_rd, 8'h05);
        step("R9 reload");
        chk("R9 reload srq", {7'b0, srq}, 8'h00);
        step("R9 rereport");
        chk("R9 rereport", {7'b0, srq}, 8'h01);

        // R2 level tracking
        mask_we = 1; mask_wdata = 8'h04; summ_in = 8'h01; step("R2 set"); idle();
        step("R2 lo");
        chk("R2 mss low", {7'b0, mss}, 8'h00);
        summ_in = 8'h04; step("R2 hi");
        chk("R2 mss high", {7'b0, mss}, 8'h01);

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            summ_in    = (($urandom % 4) == 0) ? 8'($urandom) : summ_in;
            mask_we    = (($urandom % 10) == 0);
            mask_wdata = 8'($urandom);
            poll       = (($urandom % 5) == 0);
            clr_stat   = (($urandom % 25) == 0);
            step("R4 random");
        end
        idle();

        rst = 1; step("R10 midrun"); rst = 0;
        chk("R10 mask", mask_rd, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule